// File: doc/BRIEF.md
# Microcode Sequencer with Single-Step Debug

This block sequences a 512-slot effects microprogram. Each sample-period tick starts one pass that presents instruction addresses from 0 upward, one per clock. The arithmetic unit executes whatever word the instruction store returns at that address. A conditional skip opcode compares the arithmetic unit's condition code against a test pattern. When the test passes, the sequencer jumps over a given number of the following instructions. A jump that would run past the last slot ends the pass early.

A 32-bit debug word is open to a host for reading and writing. It offers four things:
- A single-step mode that halts the per-sample passes. In this mode, each step strobe executes exactly one instruction at a host-chosen address, and that address then advances.
- A sticky record of the first saturation reported by the arithmetic unit, together with the address of the instruction that caused it.
- A live mirror of the condition code.
- A strobe that zeroes the delay-memory base counter. The counter lives outside this block.

Top module: `mseq_top`

## Requirements
- R1: After reset, `pc_o` is 0, `exec_o` is 0, `dbase_clr_o` is 0, and `host_rdata` reads 0 while `cc_in` is 0.
- R2: With single-step mode off, a `sample_tick` seen while idle causes the next clock to execute address 0. The address then rises by one per clock through 511. After that, `exec_o` drops and `pc_o` returns to 0.
- R3: A `sample_tick` that arrives during a pass has no effect on the address sequence. While idle, the sequencer executes nothing until a tick arrives.
- R4: Opcode value 4'hF is the skip instruction. It tests the bitwise AND of `cc_in` with bits 4:0 of `instr_y`. If the result is nonzero, the next executed address is the skip address + 1 + `instr_x[8:0]`. Otherwise it is the skip address + 1. The upper operand bits are ignored.
- R5: If the skip target computed under R4 exceeds 511, the pass ends: `exec_o` falls on the next clock and `pc_o` reads 0.
- R6: Debug-word bit 15 selects single-step mode. While it is set, sample ticks start no pass. Writing it as 1 during a pass halts that pass on the next clock.
- R7: A host write with both bit 15 and bit 14 set executes exactly one instruction, on the next clock, at the address in bits 8:0. Bits 8:0 then read back that address + 1, wrapping from 511 to 0. Bit 14 written without bit 15 executes nothing. Bits 8:0 always take the written value.
- R8: Bit 25 sets on the first executed instruction that raises `sat_in`. Bits 24:16 then hold that instruction's address. Later saturations change neither field.
- R9: A host write with bit 25 = 1 clears bit 25 and bits 24:16. A write with bit 25 = 0 leaves both unchanged.
- R10: Bits 13:9 of `host_rdata` show `cc_in` of the same cycle. Bits 31, 30:26 and 14 always read 0.
- R11: A host write with bit 31 = 1 raises `dbase_clr_o` for exactly the one clock that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Start-of-sample-period pulse |
| instr_op | input | 4 | Opcode of the instruction at `pc_o` |
| instr_x | input | 32 | X operand value; its low 9 bits are the skip count |
| instr_y | input | 32 | Y operand value; its low 5 bits are the skip test pattern |
| cc_in | input | 5 | Condition code from the arithmetic unit |
| sat_in | input | 1 | Saturation reported for the instruction at `pc_o` |
| host_wr | input | 1 | Host write strobe for the debug word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current debug word |
| pc_o | output | 9 | Instruction address being executed |
| exec_o | output | 1 | An instruction executes at `pc_o` this cycle |
| dbase_clr_o | output | 1 | One-clock pulse that zeroes the delay-memory base counter |

## Verification
The bench runs a table of skip cases that cover several situations:
- a taken skip and a failed test;
- a zero count;
- a target landing exactly on 511;
- a target one past 511;
- a skip at the last slot;
- operands with garbage in their upper bits.

An adder carry error or a wrong test mask shows up as a wrong next address, or as a pass that runs on past 511. Other checks aim at the places where the block is most likely to slip:
- A mid-pass tick must not restart the pass at 0.
- A step must execute exactly once, and its address must wrap.
- A strobe without the mode bit must do nothing.
- A second saturation must not overwrite the first.
- Writing 0 to the sticky bit must not clear it.

A design that got these wrong would, in turn, re-run instructions, loop in step mode, or report the wrong saturation site.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    // Debug word field positions (host-visible contract)
    localparam int DBG_W          = 32;
    localparam int BIT_DBASE_CLR  = 31;
    localparam int BIT_SAT_FLAG   = 25;
    localparam int SAT_ADDR_LSB   = 16;
    localparam int BIT_STEP_MODE  = 15;
    localparam int BIT_STEP_GO    = 14;
    localparam int CC_LSB         = 9;
    localparam int STEP_ADDR_LSB  = 0;

    // Opcode of the conditional skip instruction
    localparam logic [3:0] OP_SKIP = 4'hF;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_STEP = 2'd2
    } seq_state_e;

endpackage

// File: rtl/mseq_next_addr.sv
// Next-address unit: plain increment or conditional skip, plus end-of-pass detect.
module mseq_next_addr
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CC_W   = 5,
    parameter int OP_W   = 4,
    parameter int OPND_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OP_W-1:0]   op,
    input  logic [OPND_W-1:0] opnd_x,
    input  logic [OPND_W-1:0] opnd_y,
    input  logic [CC_W-1:0]   cc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pass_end,
    output logic              skip_taken
);
    localparam int SUM_W = ADDR_W + 2;

    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] target;
    logic             is_skip;

    generate
        if (OPND_W > ADDR_W) begin : g_x_hi
            logic unused_x_hi;
            assign unused_x_hi = ^opnd_x[OPND_W-1:ADDR_W];
        end
        if (OPND_W > CC_W) begin : g_y_hi
            logic unused_y_hi;
            assign unused_y_hi = ^opnd_y[OPND_W-1:CC_W];
        end
    endgenerate

    always_comb begin
        is_skip    = (op == OP_W'(OP_SKIP));
        skip_taken = is_skip && (|(cc & opnd_y[CC_W-1:0]));
        span       = skip_taken ? {2'b00, opnd_x[ADDR_W-1:0]} : '0;
        target     = {2'b00, pc} + SUM_W'(1) + span;
        pass_end   = |target[SUM_W-1:ADDR_W];
        next_pc    = target[ADDR_W-1:0];
    end

endmodule

// File: rtl/mseq_sat_capture.sv
// Sticky first-saturation recorder; clear beats capture in the same cycle.
module mseq_sat_capture #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sat_event,
    input  logic [ADDR_W-1:0] sat_pc,
    input  logic              clear,
    output logic              flag,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
    } sat_regs_t;

    sat_regs_t sat_d, sat_q;

    always_comb begin
        sat_d = sat_q;
        if (clear) begin
            sat_d.flag = 1'b0;
            sat_d.addr = '0;
        end else if (sat_event && !sat_q.flag) begin
            sat_d.flag = 1'b1;
            sat_d.addr = sat_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_q <= '0;
        end else begin
            sat_q <= sat_d;
        end
    end

    assign flag = sat_q.flag;
    assign addr = sat_q.addr;

endmodule

// File: rtl/mseq_dbg_pack.sv
// Assembles the host-visible debug word from its fields.
module mseq_dbg_pack
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CC_W   = 5
) (
    input  logic              sat_flag,
    input  logic [ADDR_W-1:0] sat_addr,
    input  logic              step_mode,
    input  logic [CC_W-1:0]   cc,
    input  logic [ADDR_W-1:0] step_addr,
    output logic [DBG_W-1:0]  word
);
    always_comb begin
        word                               = '0;
        word[BIT_SAT_FLAG]                 = sat_flag;
        word[SAT_ADDR_LSB +: ADDR_W]       = sat_addr;
        word[BIT_STEP_MODE]                = step_mode;
        word[CC_LSB +: CC_W]               = cc;
        word[STEP_ADDR_LSB +: ADDR_W]      = step_addr;
    end

endmodule

// File: rtl/mseq_top.sv
// Microprogram sequencer: per-sample passes, conditional skip, host single-step.
module mseq_top
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CC_W   = 5,
    parameter int OP_W   = 4,
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic [OP_W-1:0]   instr_op,
    input  logic [OPND_W-1:0] instr_x,
    input  logic [OPND_W-1:0] instr_y,
    input  logic [CC_W-1:0]   cc_in,
    input  logic              sat_in,
    input  logic              host_wr,
    input  logic [DBG_W-1:0]  host_wdata,
    output logic [DBG_W-1:0]  host_rdata,
    output logic [ADDR_W-1:0] pc_o,
    output logic              exec_o,
    output logic              dbase_clr_o
);
    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic              step_mode;
        logic [ADDR_W-1:0] step_addr;
        logic              dbase_clr;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [ADDR_W-1:0] adv_pc;
    logic              adv_end;
    logic              adv_skip;
    logic              sat_flag;
    logic [ADDR_W-1:0] sat_addr;
    logic              exec;
    logic              wr_step_go;
    logic              unused_wdata;

    assign unused_wdata = ^{host_wdata[30:26], host_wdata[24:16], host_wdata[13:9],
                            adv_skip};

    mseq_next_addr #(
        .ADDR_W (ADDR_W),
        .CC_W   (CC_W),
        .OP_W   (OP_W),
        .OPND_W (OPND_W)
    ) i_next_addr (
        .pc         (seq_q.pc),
        .op         (instr_op),
        .opnd_x     (instr_x),
        .opnd_y     (instr_y),
        .cc         (cc_in),
        .next_pc    (adv_pc),
        .pass_end   (adv_end),
        .skip_taken (adv_skip)
    );

    assign exec       = (seq_q.state != SEQ_IDLE);
    assign wr_step_go = host_wr && host_wdata[BIT_STEP_MODE] && host_wdata[BIT_STEP_GO];

    // Next-state computation
    always_comb begin
        seq_d           = seq_q;
        seq_d.dbase_clr = host_wr && host_wdata[BIT_DBASE_CLR];

        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (sample_tick && !seq_q.step_mode) begin
                    seq_d.state = SEQ_RUN;
                    seq_d.pc    = '0;
                end
            end
            SEQ_RUN: begin
                if (adv_end) begin
                    seq_d.state = SEQ_IDLE;
                    seq_d.pc    = '0;
                end else begin
                    seq_d.pc    = adv_pc;
                end
            end
            SEQ_STEP: begin
                seq_d.state     = SEQ_IDLE;
                seq_d.pc        = '0;
                seq_d.step_addr = seq_q.pc + ADDR_W'(1);
            end
            default: begin
                seq_d.state = SEQ_IDLE;
                seq_d.pc    = '0;
            end
        endcase

        // Host writes take precedence over sequencing
        if (host_wr) begin
            seq_d.step_mode = host_wdata[BIT_STEP_MODE];
            seq_d.step_addr = host_wdata[STEP_ADDR_LSB +: ADDR_W];
            if (host_wdata[BIT_STEP_MODE]) begin
                seq_d.state = SEQ_IDLE;
                seq_d.pc    = '0;
            end
            if (wr_step_go) begin
                seq_d.state = SEQ_STEP;
                seq_d.pc    = host_wdata[STEP_ADDR_LSB +: ADDR_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    mseq_sat_capture #(
        .ADDR_W (ADDR_W)
    ) i_sat_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sat_event (exec && sat_in),
        .sat_pc    (seq_q.pc),
        .clear     (host_wr && host_wdata[BIT_SAT_FLAG]),
        .flag      (sat_flag),
        .addr      (sat_addr)
    );

    mseq_dbg_pack #(
        .ADDR_W (ADDR_W),
        .CC_W   (CC_W)
    ) i_dbg_pack (
        .sat_flag  (sat_flag),
        .sat_addr  (sat_addr),
        .step_mode (seq_q.step_mode),
        .cc        (cc_in),
        .step_addr (seq_q.step_addr),
        .word      (host_rdata)
    );

    assign pc_o        = seq_q.pc;
    assign exec_o      = exec;
    assign dbase_clr_o = seq_q.dbase_clr;

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CC_W   = 5,
    parameter int OP_W   = 4,
    parameter int OPND_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   instr_op,
    input logic [OPND_W-1:0] instr_x,
    input logic [OPND_W-1:0] instr_y,
    input logic [CC_W-1:0]   cc_in,
    input logic              host_wr,
    input logic [DBG_W-1:0]  host_wdata,
    input logic [DBG_W-1:0]  host_rdata,
    input logic [ADDR_W-1:0] pc_o,
    input logic              exec_o,
    input logic              dbase_clr_o
);
    logic [ADDR_W+1:0] chk_target;
    logic              chk_hit;
    logic              halt_wr;
    logic              unused_chk;

    assign unused_chk = ^{instr_x[OPND_W-1:ADDR_W], instr_y[OPND_W-1:CC_W]};
    assign chk_target = {2'b00, pc_o} + (ADDR_W+2)'(1) + {2'b00, instr_x[ADDR_W-1:0]};
    assign chk_hit    = (instr_op == OP_W'(OP_SKIP)) && (|(cc_in & instr_y[CC_W-1:0]));
    assign halt_wr    = host_wr && host_wdata[BIT_STEP_MODE];

    // R1 R2
    idle_pc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |-> pc_o == '0);

    // R2
    run_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && !host_rdata[BIT_STEP_MODE] && instr_op != OP_W'(OP_SKIP)
         && pc_o != '1 && !halt_wr)
        |=> exec_o && pc_o == $past(pc_o) + ADDR_W'(1));

    // R4
    skip_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && !host_rdata[BIT_STEP_MODE] && chk_hit && !chk_target[ADDR_W+1]
         && !chk_target[ADDR_W] && !halt_wr)
        |=> exec_o && pc_o == $past(chk_target[ADDR_W-1:0]));

    // R6 R7
    step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && host_rdata[BIT_STEP_MODE]
         && !(host_wr && host_wdata[BIT_STEP_MODE] && host_wdata[BIT_STEP_GO]))
        |=> !exec_o);

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[BIT_SAT_FLAG] && !(host_wr && host_wdata[BIT_SAT_FLAG]))
        |=> host_rdata[BIT_SAT_FLAG]
            && $stable(host_rdata[SAT_ADDR_LSB +: ADDR_W]));

    // R9
    sat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[BIT_SAT_FLAG])
        |=> !host_rdata[BIT_SAT_FLAG] && host_rdata[SAT_ADDR_LSB +: ADDR_W] == '0);

    // R11
    dbase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbase_clr_o |-> $past(host_wr && host_wdata[BIT_DBASE_CLR]));

endmodule

bind mseq_top mseq_checker #(
    .ADDR_W (ADDR_W),
    .CC_W   (CC_W),
    .OP_W   (OP_W),
    .OPND_W (OPND_W)
) i_mseq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_op    (instr_op),
    .instr_x     (instr_x),
    .instr_y     (instr_y),
    .cc_in       (cc_in),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .pc_o        (pc_o),
    .exec_o      (exec_o),
    .dbase_clr_o (dbase_clr_o)
);

// File: tb/test_mseq_top.sv
module test_mseq_top;
    localparam int AW    = 9;
    localparam int CCW   = 5;
    localparam int OPW   = 4;
    localparam int OW    = 32;
    localparam int SLOTS = 1 << AW;

    typedef struct packed {
        logic [AW-1:0]  at;
        logic [CCW-1:0] cc;
        logic [OW-1:0]  test;
        logic [OW-1:0]  cnt;
        logic [AW:0]    exp;   // bit AW set = pass ended
    } skip_vec_t;

    localparam int NVEC = 8;
    localparam skip_vec_t SKIP_VECS [NVEC] = '{
        '{at: 9'd5,   cc: 5'b00001, test: 32'h0000_0001, cnt: 32'h0000_0203, exp: 10'd9},
        '{at: 9'd5,   cc: 5'b00010, test: 32'hFFFF_FFE1, cnt: 32'h0000_0003, exp: 10'd6},
        '{at: 9'd100, cc: 5'b10000, test: 32'h0000_0018, cnt: 32'h0000_0000, exp: 10'd101},
        '{at: 9'd200, cc: 5'b00000, test: 32'h0000_001F, cnt: 32'h0000_0032, exp: 10'd201},
        '{at: 9'd500, cc: 5'b00100, test: 32'h0000_0004, cnt: 32'h0000_000A, exp: 10'd511},
        '{at: 9'd500, cc: 5'b00100, test: 32'h0000_0004, cnt: 32'h0000_000B, exp: 10'h200},
        '{at: 9'd511, cc: 5'b00001, test: 32'h0000_0001, cnt: 32'h0000_0000, exp: 10'h200},
        '{at: 9'd0,   cc: 5'b01000, test: 32'h0000_0008, cnt: 32'h0000_00FF, exp: 10'd256}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sample_tick = 1'b0;
    logic [OPW-1:0]  instr_op;
    logic [OW-1:0]   instr_x;
    logic [OW-1:0]   instr_y;
    logic [CCW-1:0]  cc_in = '0;
    logic            sat_in;
    logic            host_wr = 1'b0;
    logic [31:0]     host_wdata = '0;
    logic [31:0]     host_rdata;
    logic [AW-1:0]   pc_o;
    logic            exec_o;
    logic            dbase_clr_o;

    logic [OPW-1:0]  mem_op  [SLOTS];
    logic [OW-1:0]   mem_x   [SLOTS];
    logic [OW-1:0]   mem_y   [SLOTS];
    logic            mem_sat [SLOTS];

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign instr_op = mem_op[pc_o];
    assign instr_x  = mem_x[pc_o];
    assign instr_y  = mem_y[pc_o];
    assign sat_in   = mem_sat[pc_o];

    mseq_top i_mseq_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .instr_op    (instr_op),
        .instr_x     (instr_x),
        .instr_y     (instr_y),
        .cc_in       (cc_in),
        .sat_in      (sat_in),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .pc_o        (pc_o),
        .exec_o      (exec_o),
        .dbase_clr_o (dbase_clr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int a = 0; a < SLOTS; a++) begin
            mem_op[a]  = '0;
            mem_x[a]   = '0;
            mem_y[a]   = '0;
            mem_sat[a] = 1'b0;
        end
    endtask

    // Returns on the negedge where address 0 is executing
    task automatic start_pass();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 2 * SLOTS && exec_o; g++) @(negedge clk);
    endtask

    // Returns on the negedge after the write has been clocked in
    task automatic host_write(input logic [31:0] d);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = d;
        @(negedge clk);
        host_wr    = 1'b0;
        host_wdata = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clear_prog();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pc", 32'(pc_o), 32'd0);
        check("R1 exec", 32'(exec_o), 32'd0);
        check("R1 rdata", host_rdata, 32'd0);
        check("R1 dbase_clr", 32'(dbase_clr_o), 32'd0);

        // R2 full free-run pass
        begin
            int errs = 0;
            start_pass();
            for (int k = 0; k < SLOTS; k++) begin
                if (!exec_o || pc_o != AW'(k)) errs++;
                @(negedge clk);
            end
            check("R2 sequence mismatches", 32'(errs), 32'd0);
            check("R2 exec after 511", 32'(exec_o), 32'd0);
            check("R2 pc after 511", 32'(pc_o), 32'd0);
        end

        // R3 tick during pass ignored, idle waits
        start_pass();
        repeat (9) @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        check("R3 pc after mid-pass tick", 32'(pc_o), 32'd10);
        wait_idle();
        repeat (5) @(negedge clk);
        check("R3 idle without tick", 32'(exec_o), 32'd0);

        // R4 R5 skip vector table
        for (int i = 0; i < NVEC; i++) begin
            skip_vec_t v;
            logic [AW:0] act;
            bit seen;
            v    = SKIP_VECS[i];
            seen = 1'b0;
            act  = '0;
            clear_prog();
            mem_op[v.at] = 4'hF;
            mem_x[v.at]  = v.cnt;
            mem_y[v.at]  = v.test;
            cc_in        = v.cc;
            start_pass();
            for (int g = 0; g < 2 * SLOTS && !seen; g++) begin
                if (exec_o && pc_o == v.at) begin
                    seen = 1'b1;
                    @(negedge clk);
                    act = exec_o ? {1'b0, pc_o} : 10'h200;
                end else begin
                    @(negedge clk);
                end
            end
            check(v.exp[AW] ? "R5 skip ends pass" : "R4 skip next address",
                  32'(act), 32'(v.exp));
            if (v.exp[AW]) check("R5 pc after end", 32'(pc_o), 32'd0);
            wait_idle();
        end
        cc_in = '0;

        // R8 R9 saturation capture and clear
        clear_prog();
        mem_sat[7]  = 1'b1;
        mem_sat[20] = 1'b1;
        start_pass();
        wait_idle();
        check("R8 sat flag", 32'(host_rdata[25]), 32'd1);
        check("R8 first sat addr", 32'(host_rdata[24:16]), 32'd7);
        host_write(32'h0000_0000);
        check("R9 write 0 keeps flag", 32'(host_rdata[25]), 32'd1);
        check("R9 write 0 keeps addr", 32'(host_rdata[24:16]), 32'd7);
        host_write(32'h0200_0000);
        check("R9 clear flag", 32'(host_rdata[25]), 32'd0);
        check("R9 clear addr", 32'(host_rdata[24:16]), 32'd0);
        mem_sat[7] = 1'b0;
        start_pass();
        wait_idle();
        check("R8 recapture addr", 32'(host_rdata[24:16]), 32'd20);
        host_write(32'h0200_0000);

        // R6 step mode blocks ticks
        host_write(32'h0000_8000);
        check("R6 step mode bit", 32'(host_rdata[15]), 32'd1);
        start_pass();
        check("R6 tick ignored", 32'(exec_o), 32'd0);
        repeat (3) @(negedge clk);
        check("R6 still idle", 32'(exec_o), 32'd0);

        // R7 single step
        host_write(32'h0000_C000 | 32'd42);
        check("R7 step exec", 32'(exec_o), 32'd1);
        check("R7 step pc", 32'(pc_o), 32'd42);
        @(negedge clk);
        check("R7 one instruction only", 32'(exec_o), 32'd0);
        check("R7 step addr advanced", 32'(host_rdata[8:0]), 32'd43);
        host_write(32'h0000_C000 | 32'd511);
        check("R7 step at 511", 32'(pc_o), 32'd511);
        @(negedge clk);
        check("R7 step addr wraps", 32'(host_rdata[8:0]), 32'd0);
        host_write(32'h0000_4000 | 32'd10);
        check("R7 strobe without mode", 32'(exec_o), 32'd0);
        check("R7 mode cleared", 32'(host_rdata[15]), 32'd0);
        check("R7 addr written", 32'(host_rdata[8:0]), 32'd10);
        @(negedge clk);
        check("R7 still no exec", 32'(exec_o), 32'd0);

        // R6 halt a running pass
        start_pass();
        repeat (5) @(negedge clk);
        host_write(32'h0000_8000);
        check("R6 halt pass", 32'(exec_o), 32'd0);
        host_write(32'h0000_0000);

        // R10 R11 mirror, zero bits, base-clear pulse
        cc_in = 5'h15;
        host_write(32'h8000_4000);
        check("R11 pulse high", 32'(dbase_clr_o), 32'd1);
        check("R10 cc mirror", 32'(host_rdata[13:9]), 32'h15);
        check("R10 bit31 zero", 32'(host_rdata[31]), 32'd0);
        check("R10 bits30:26 zero", 32'(host_rdata[30:26]), 32'd0);
        check("R10 bit14 zero", 32'(host_rdata[14]), 32'd0);
        @(negedge clk);
        check("R11 pulse one cycle", 32'(dbase_clr_o), 32'd0);
        cc_in = 5'h0A;
        #1;
        check("R10 cc follows", 32'(host_rdata[13:9]), 32'h0A);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule